// File: doc/BRIEF.md
# Register-Programmable SPI Master Controller

This block is an SPI master that sits behind a simple byte-addressed register port. Software programs a command word that sets the frame length, the bit order and the clock phase and polarity. It sets a bit-rate divisor and turns the interface on through a control register. It then moves frames by writing the data register. Each write sends one frame of 8 to 16 bits on `sck_o`/`mosi_o`. The active-low select `cs_no` is tied to the enable bit, so a multi-frame message is framed by software.

In full-duplex mode every transmitted frame also captures one frame from `miso_i` into a receive buffer. To read a device, software writes dummy data, and that write generates the clocks. In transmit-only mode the received bits are thrown away. Two single-entry buffers carry status flags: transmit-empty and receive-full. If a frame completes while the previous one is still unread, an overrun flag is set. Each flag has its own interrupt enable, and the enabled flags are merged onto one interrupt line.

Register offsets: control 0x00, status 0x03, data 0x04 (16-bit), rate 0x0A, command 0x10 (16-bit). All other offsets read as zero and ignore writes.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, status reads 0x20 (transmit-empty only), the data register reads 0, `cs_no` is 1, `sck_o` is 0 and `irq_o` is 0.
- R2: `cs_no` is the inverse of control bit 6 (enable). Frames only run while that bit is 1, and clearing it stops shifting from the next cycle.
- R3: Writing the data register clears status bit 5 (transmit-empty) in the following cycle. The bit sets again one cycle later, when the word moves into the shifter. Status bit 1 (busy) is 1 while a frame is shifting.
- R4: Each SCK half-period lasts rate+1 system clocks, where rate is the 8-bit value at 0x0A. From the first SCK edge to the last edge spans (2L−1)(rate+1) clocks for an L-bit frame.
- R5: Command bits 11:8 hold L−1 for L from 8 to 16, and any smaller value gives 8 bits. Command bit 12 set sends the LSB first, clear sends the MSB first. A frame produces exactly 2L SCK edges.
- R6: Command bit 1 (CPOL) sets the SCK idle level. With command bit 0 (CPHA) clear, data is sampled on the leading edge and changes on the trailing edge. With CPHA set, data changes on the leading edge and is sampled on the trailing edge.
- R7: In full-duplex mode (control bit 1 clear), the received frame is right-aligned in the data register and status bit 7 (receive-full) sets. A read of the data register clears bit 7.
- R8: In transmit-only mode (control bit 1 set), a frame leaves status bit 7 clear and leaves the data register at its previous value.
- R9: A frame that completes while receive-full is set sets status bit 0 (overrun) and is dropped. Writing 0 to status bit 0 clears overrun, and writing 1 leaves it unchanged.
- R10: `irq_o` is high when any of the following holds: receive-full with control bit 7 set, transmit-empty with control bit 5 set, or overrun with control bit 4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on the data register) |
| addr_i | input | 6 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 1 | Slave select, active low |
| irq_o | output | 1 | Merged interrupt |

## Verification
The assertions check the following on every cycle: a disabled interface stops the shifter, a load only takes a word that is present, SCK holds steady between divider ticks, a frame in transmit-only mode never raises receive-full, a completed frame is always captured, and an overrun frame never overwrites the buffer. Only the bench scenarios can show the serial behaviour itself. This covers the bit order and its alignment for several lengths, which edge samples in each of the four clock modes, the exact frame duration for each rate, the write-0 clearing of overrun and the interrupt combinations. The bench does this with a slave model that records MOSI and drives MISO on the edges the mode calls for.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LEN_W  = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 6'h03;
  localparam logic [ADDR_W-1:0] OFS_DATA = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_RATE = 6'h0A;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h10;

  // control bit positions
  localparam int unsigned CB_RXIE = 7;
  localparam int unsigned CB_EN   = 6;
  localparam int unsigned CB_TXIE = 5;
  localparam int unsigned CB_ERIE = 4;
  localparam int unsigned CB_TXO  = 1;

  // status bit positions
  localparam int unsigned SB_RXF  = 7;
  localparam int unsigned SB_TXE  = 5;
  localparam int unsigned SB_BUSY = 1;
  localparam int unsigned SB_OVR  = 0;

  typedef struct packed {
    logic             clk_dly_en;
    logic             neg_dly_en;
    logic             gap_dly_en;
    logic             lsb_first;
    logic [LEN_W-1:0] len_m1;
    logic             keep_sel;
    logic             rsvd;
    logic [1:0]       sel_num;
    logic [1:0]       div_ext;
    logic             cpol;
    logic             cpha;
  } cmd_t;
endpackage

// File: rtl/spim_divider.sv
module spim_divider #(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [RATE_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned MIN_LEN = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   enable_i,
  input  logic                   cpol_i,
  input  logic                   cpha_i,
  input  logic                   lsb_first_i,
  input  logic [LEN_W-1:0]       len_m1_i,
  input  logic                   tick_i,
  input  logic                   tx_valid_i,
  input  logic [(1<<LEN_W)-1:0]  tx_word_i,
  input  logic                   miso_i,
  output logic                   load_o,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [(1<<LEN_W)-1:0]  rx_word_o,
  output logic                   sck_o,
  output logic                   mosi_o
);
  localparam int unsigned FRAME_W = 1 << LEN_W;
  localparam logic [LEN_W-1:0] TOP   = LEN_W'(FRAME_W - 1);
  localparam logic [LEN_W-1:0] FLOOR = LEN_W'(MIN_LEN - 1);

  logic busy_q, sck_q, mosi_q, lsb_q, cpha_q;
  logic [LEN_W-1:0]   len_q, len_eff;
  logic [LEN_W:0]     half_q;
  logic [FRAME_W-1:0] tx_sr_q, rx_sr_q, tx_aligned, rx_next;
  logic leading, sample, last;

  function automatic logic head(input logic [FRAME_W-1:0] v, input logic lsb);
    return lsb ? v[0] : v[FRAME_W-1];
  endfunction

  function automatic logic [FRAME_W-1:0] adv(input logic [FRAME_W-1:0] v, input logic lsb);
    return lsb ? (v >> 1) : (v << 1);
  endfunction

  assign len_eff    = (len_m1_i < FLOOR) ? FLOOR : len_m1_i;
  // MSB-first frames are left-aligned so the head bit is always the top bit
  assign tx_aligned = lsb_first_i ? tx_word_i : (tx_word_i << (TOP - len_eff));
  assign load_o     = !busy_q && enable_i && tx_valid_i;
  assign leading    = !half_q[0];
  assign sample     = leading ^ cpha_q;
  assign last       = (half_q == {len_q, 1'b1});
  assign rx_next    = !sample ? rx_sr_q :
                      lsb_q   ? {miso_i, rx_sr_q[FRAME_W-1:1]} :
                                {rx_sr_q[FRAME_W-2:0], miso_i};
  assign done_o     = busy_q && tick_i && last;
  assign rx_word_o  = lsb_q ? (rx_next >> (TOP - len_q)) : rx_next;
  assign busy_o     = busy_q;
  assign sck_o      = sck_q;
  assign mosi_o     = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b0;
      mosi_q  <= 1'b0;
      lsb_q   <= 1'b0;
      cpha_q  <= 1'b0;
      len_q   <= '0;
      half_q  <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else if (!enable_i) begin
      busy_q <= 1'b0;
      sck_q  <= cpol_i;
    end else if (load_o) begin
      busy_q  <= 1'b1;
      half_q  <= '0;
      len_q   <= len_eff;
      lsb_q   <= lsb_first_i;
      cpha_q  <= cpha_i;
      sck_q   <= cpol_i;
      rx_sr_q <= '0;
      if (cpha_i) begin
        tx_sr_q <= tx_aligned;
      end else begin
        mosi_q  <= head(tx_aligned, lsb_first_i);
        tx_sr_q <= adv(tx_aligned, lsb_first_i);
      end
    end else if (busy_q) begin
      if (tick_i) begin
        sck_q   <= ~sck_q;
        half_q  <= half_q + 1'b1;
        rx_sr_q <= rx_next;
        if (!sample && !last) begin
          mosi_q  <= head(tx_sr_q, lsb_q);
          tx_sr_q <= adv(tx_sr_q, lsb_q);
        end
        if (last) busy_q <= 1'b0;
      end
    end else begin
      sck_q <= cpol_i;
    end
  end

  assert_sck_holds_between_ticks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && $past(busy_q) && !$past(tick_i)) |-> $stable(sck_q));
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int unsigned RATE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              load_i,
  input  logic              done_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rx_word_i,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_valid_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              enable_o,
  output logic              cpol_o,
  output logic              cpha_o,
  output logic              lsb_first_o,
  output logic [LEN_W-1:0]  len_m1_o,
  output logic              irq_o
);
  logic [7:0]        ctrl_q, stat;
  logic [RATE_W-1:0] rate_q;
  cmd_t              cmd_q;
  logic [DATA_W-1:0] tx_word_q, rx_word_q;
  logic              tx_full_q, rx_full_q, ovr_q;
  logic              wr_ctrl, wr_stat, wr_data, wr_rate, wr_cmd, rd_data;

  assign wr_ctrl = wr_en_i && (addr_i == OFS_CTRL);
  assign wr_stat = wr_en_i && (addr_i == OFS_STAT);
  assign wr_data = wr_en_i && (addr_i == OFS_DATA);
  assign wr_rate = wr_en_i && (addr_i == OFS_RATE);
  assign wr_cmd  = wr_en_i && (addr_i == OFS_CMD);
  assign rd_data = rd_en_i && (addr_i == OFS_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      rate_q    <= '0;
      cmd_q     <= '0;
      tx_word_q <= '0;
      tx_full_q <= 1'b0;
      rx_word_q <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[7:0];
      if (wr_rate) rate_q <= wdata_i[RATE_W-1:0];
      if (wr_cmd)  cmd_q  <= cmd_t'(wdata_i);
      if (wr_data) begin
        tx_word_q <= wdata_i;
        tx_full_q <= 1'b1;
      end else if (load_i) begin
        tx_full_q <= 1'b0;
      end
      if (rd_data) rx_full_q <= 1'b0;
      if (wr_stat && !wdata_i[SB_OVR]) ovr_q <= 1'b0;
      if (done_i && !ctrl_q[CB_TXO]) begin
        if (rx_full_q && !rd_data) begin
          ovr_q <= 1'b1;
        end else begin
          rx_word_q <= rx_word_i;
          rx_full_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    stat          = '0;
    stat[SB_RXF]  = rx_full_q;
    stat[SB_TXE]  = !tx_full_q;
    stat[SB_BUSY] = busy_i;
    stat[SB_OVR]  = ovr_q;
    case (addr_i)
      OFS_CTRL: rdata_o = DATA_W'(ctrl_q);
      OFS_STAT: rdata_o = DATA_W'(stat);
      OFS_DATA: rdata_o = rx_word_q;
      OFS_RATE: rdata_o = DATA_W'(rate_q);
      OFS_CMD:  rdata_o = cmd_q;
      default:  rdata_o = '0;
    endcase
  end

  assign tx_word_o   = tx_word_q;
  assign tx_valid_o  = tx_full_q;
  assign rate_o      = rate_q;
  assign enable_o    = ctrl_q[CB_EN];
  assign cpol_o      = cmd_q.cpol;
  assign cpha_o      = cmd_q.cpha;
  assign lsb_first_o = cmd_q.lsb_first;
  assign len_m1_o    = cmd_q.len_m1;
  assign irq_o       = (ctrl_q[CB_RXIE] && rx_full_q) ||
                       (ctrl_q[CB_TXIE] && !tx_full_q) ||
                       (ctrl_q[CB_ERIE] && ovr_q);

  assert_disable_stops_shift_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CB_EN] |=> !busy_i);
  assert_load_has_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> tx_full_q);
  assert_capture_sets_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ctrl_q[CB_TXO] && !rx_full_q) |=> rx_full_q);
  assert_txonly_no_full_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && ctrl_q[CB_TXO]) |=> !$rose(rx_full_q));
  assert_overrun_drops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !ctrl_q[CB_TXO] && rx_full_q && !rd_data) |=> (ovr_q && $stable(rx_word_q)));
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spim_pkg::*;
#(
  parameter int unsigned RATE_W  = 8,
  parameter int unsigned MIN_LEN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_no,
  output logic              irq_o
);
  logic [DATA_W-1:0] tx_word, rx_word;
  logic [RATE_W-1:0] rate;
  logic [LEN_W-1:0]  len_m1;
  logic tx_valid, load, done, busy, tick, enable, cpol, cpha, lsb_first;

  spim_regs #(.RATE_W(RATE_W)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .load_i(load), .done_i(done), .busy_i(busy), .rx_word_i(rx_word),
    .tx_word_o(tx_word), .tx_valid_o(tx_valid), .rate_o(rate),
    .enable_o(enable), .cpol_o(cpol), .cpha_o(cpha),
    .lsb_first_o(lsb_first), .len_m1_o(len_m1), .irq_o
  );

  spim_divider #(.RATE_W(RATE_W)) i_div (
    .clk_i, .rst_ni, .run_i(busy), .rate_i(rate), .tick_o(tick)
  );

  spim_shifter #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) i_shift (
    .clk_i, .rst_ni, .enable_i(enable), .cpol_i(cpol), .cpha_i(cpha),
    .lsb_first_i(lsb_first), .len_m1_i(len_m1), .tick_i(tick),
    .tx_valid_i(tx_valid), .tx_word_i(tx_word), .miso_i,
    .load_o(load), .busy_o(busy), .done_o(done), .rx_word_o(rx_word),
    .sck_o, .mosi_o
  );

  assign cs_no = ~enable;
endmodule

// File: tb/test_spi_host_ctrl.sv
`timescale 1ns/1ps
module test_spi_host_ctrl;
  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h03, A_DATA = 6'h04,
                         A_RATE = 6'h0A, A_CMD = 6'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic sck_o, mosi_o, miso, cs_no, irq_o;
  int n_chk = 0, n_err = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  spi_host_ctrl i_spi_host_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso), .cs_no(cs_no), .irq_o(irq_o)
  );

  // slave model
  logic b_act = 1'b0, b_cpol = 1'b0, b_cpha = 1'b0, b_lsb = 1'b0, b_prev;
  int b_len = 8, b_k, b_edges;
  logic [15:0] b_sw = '0, b_mt;
  realtime t_first, t_last;

  always_comb begin
    int idx;
    idx = b_lsb ? b_k : (b_len - 1 - b_k);
    if (b_k >= b_len || idx < 0) miso = 1'b0;
    else miso = b_sw[idx[3:0]];
  end

  always @(sck_o or b_act) begin
    if (!b_act) begin
      b_k = 0; b_edges = 0; b_mt = '0; b_prev = sck_o;
    end else if (sck_o !== b_prev) begin
      b_prev = sck_o;
      if (!cs_no) begin
        if (b_edges == 0) t_first = $realtime;
        t_last = $realtime;
        b_edges++;
        if (sck_o != b_cpol) begin
          if (!b_cpha && b_k < 16) b_mt[b_k[3:0]] = mosi_o;
        end else begin
          if (b_cpha && b_k < 16) b_mt[b_k[3:0]] = mosi_o;
          b_k++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic int eff_len(input int field);
    return (field < 7) ? 8 : field + 1;
  endfunction

  int cur_rate;
  logic [15:0] cur_tx;

  task automatic start_frame(input logic [15:0] tx, input logic [15:0] sw, input int field,
                             input bit lsb, input bit cpol, input bit cpha, input int rate);
    bus_wr(A_CMD, {3'b000, lsb, field[3:0], 6'b0, cpol, cpha});
    bus_wr(A_RATE, 16'(rate));
    repeat (2) @(negedge clk);
    b_act = 1'b0;
    #1;
    b_len = eff_len(field); b_lsb = lsb; b_cpol = cpol; b_cpha = cpha; b_sw = sw;
    b_act = 1'b1;
    cur_rate = rate; cur_tx = tx;
    @(negedge clk);
    bus_wr(A_DATA, tx);
  endtask

  task automatic wait_frame();
    logic [15:0] s, exp_t;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 20000; i++) begin
      bus_rd(A_STAT, s);
      if (!s[1] && s[5]) break;
    end
    chk("R5 edge count", b_edges, 2 * b_len);
    exp_t = '0;
    for (int k = 0; k < b_len; k++) exp_t[k] = b_lsb ? cur_tx[k] : cur_tx[b_len - 1 - k];
    chk("R5/R6 mosi bit sequence", b_mt, exp_t);
    chk("R4 frame span in clocks", int'((t_last - t_first) / 20.0), (2 * b_len - 1) * (cur_rate + 1));
    chk("R6 sck idle level", sck_o, b_cpol);
    b_act = 1'b0;
  endtask

  function automatic logic [15:0] mask(input logic [15:0] v, input int len);
    return v & 16'((32'h1 << len) - 1);
  endfunction

  task automatic t_reset();
    logic [15:0] d;
    bus_rd(A_STAT, d);  chk("R1 status", d, 16'h0020);
    bus_rd(A_DATA, d);  chk("R1 data", d, 16'h0000);
    chk("R1 cs_no", cs_no, 1'b1);
    chk("R1 sck", sck_o, 1'b0);
    chk("R1 irq", irq_o, 1'b0);
  endtask

  task automatic t_select();
    bus_wr(A_CTRL, 16'h0040);  #1 chk("R2 select asserted", cs_no, 1'b0);
    bus_wr(A_CTRL, 16'h0000);  #1 chk("R2 select negated", cs_no, 1'b1);
    bus_wr(A_DATA, 16'h00F0);
    repeat (40) @(negedge clk);
    chk("R2 no clock while disabled", sck_o, 1'b0);
    bus_wr(A_CTRL, 16'h0048);
    b_act = 1'b0; #1;
    b_len = 8; b_lsb = 0; b_cpol = 0; b_cpha = 0; b_sw = 16'h0000; b_act = 1'b1;
    cur_rate = 0; cur_tx = 16'h00F0;
    wait_frame();
    begin logic [15:0] d; bus_rd(A_DATA, d); end
  endtask

  task automatic t_txe();
    logic [15:0] s;
    start_frame(16'h005A, 16'h00C3, 7, 1'b0, 1'b0, 1'b0, 3);
    bus_rd(A_STAT, s);  chk("R3 empty clears on write", s[5], 1'b0);
    bus_rd(A_STAT, s);  chk("R3 empty sets on load", s[5], 1'b1);
    chk("R3 busy while shifting", s[1], 1'b1);
    wait_frame();
    bus_rd(A_STAT, s);  chk("R3 busy clear after frame", s[1], 1'b0);
    bus_rd(A_DATA, s);  chk("R7 received word", s, 16'h00C3);
  endtask

  task automatic t_modes();
    logic [15:0] d;
    for (int m = 0; m < 4; m++) begin
      start_frame(16'h00B1 ^ 16'(m), 16'h0036 + 16'(m * 17), 7, 1'b0, m[1], m[0], 1);
      wait_frame();
      bus_rd(A_STAT, d);  chk("R7 receive-full set", d[7], 1'b1);
      bus_rd(A_DATA, d);  chk("R6/R7 received word per mode", d, 16'h0036 + 16'(m * 17));
      bus_rd(A_STAT, d);  chk("R7 read clears receive-full", d[7], 1'b0);
    end
  endtask

  task automatic t_lengths();
    logic [15:0] d;
    start_frame(16'hC1A5, 16'h9E37, 15, 1'b1, 1'b0, 1'b0, 0);
    wait_frame();
    bus_rd(A_DATA, d);  chk("R5 16-bit lsb-first rx", d, 16'h9E37);
    start_frame(16'h0ABC, 16'h0F5A, 11, 1'b0, 1'b1, 1'b1, 5);
    wait_frame();
    bus_rd(A_DATA, d);  chk("R5 12-bit msb-first rx", d, mask(16'h0F5A, 12));
    start_frame(16'h0081, 16'h00E4, 11, 1'b1, 1'b0, 1'b1, 2);
    wait_frame();
    bus_rd(A_DATA, d);  chk("R5 12-bit lsb-first rx", d, mask(16'h00E4, 12));
    start_frame(16'h0069, 16'h0017, 3, 1'b0, 1'b0, 0, 0);
    wait_frame();
    bus_rd(A_DATA, d);  chk("R5 short field gives 8 bits", d, 16'h0017);
  endtask

  task automatic t_txonly();
    logic [15:0] d;
    bus_wr(A_CTRL, 16'h004A);
    start_frame(16'h0033, 16'h00EE, 7, 1'b0, 1'b0, 1'b0, 1);
    wait_frame();
    bus_rd(A_STAT, d);  chk("R8 receive-full stays clear", d[7], 1'b0);
    bus_rd(A_DATA, d);  chk("R8 data register unchanged", d, 16'h0017);
    bus_wr(A_CTRL, 16'h0048);
  endtask

  task automatic t_overrun();
    logic [15:0] d;
    bus_wr(A_CTRL, 16'h0058);
    #1 chk("R10 no irq before error", irq_o, 1'b0);
    start_frame(16'h0011, 16'h00A5, 7, 1'b0, 1'b0, 1'b0, 0);
    wait_frame();
    start_frame(16'h0022, 16'h003C, 7, 1'b0, 1'b0, 1'b0, 0);
    wait_frame();
    bus_rd(A_STAT, d);  chk("R9 overrun flagged", d[7:0], 8'hA1);
    chk("R10 irq on overrun", irq_o, 1'b1);
    bus_rd(A_DATA, d);  chk("R9 new frame dropped", d, 16'h00A5);
    bus_wr(A_STAT, 16'h0001);
    bus_rd(A_STAT, d);  chk("R9 writing 1 keeps overrun", d[0], 1'b1);
    bus_wr(A_STAT, 16'h0000);
    bus_rd(A_STAT, d);  chk("R9 writing 0 clears overrun", d[0], 1'b0);
    #1 chk("R10 irq drops with overrun", irq_o, 1'b0);
  endtask

  task automatic t_irq();
    logic [15:0] d;
    bus_wr(A_CTRL, 16'h0060);  #1 chk("R10 irq on transmit-empty", irq_o, 1'b1);
    bus_wr(A_CTRL, 16'h00C0);  #1 chk("R10 no irq with receive empty", irq_o, 1'b0);
    start_frame(16'h0044, 16'h0099, 7, 1'b0, 1'b0, 1'b0, 0);
    wait_frame();
    chk("R10 irq on receive-full", irq_o, 1'b1);
    bus_rd(A_DATA, d);
    #1 chk("R10 irq clears after read", irq_o, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_txe();
    t_modes();
    t_lengths();
    t_txonly();
    t_overrun();
    t_irq();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule